// File: doc/BRIEF.md
# Row cache read port

This block is the read side of a cache that holds one DRAM row. Inside, the row sits in a store of 128-bit lines. Outside, the row looks like a page of 32-bit words. The upper column bits choose a line, and the two lowest column bits steer one word of that line onto the data bus. A read needs only chip select and output enable. No row-activation cycle is involved. The row is whichever one was last loaded through the fill port, so reads can carry on while the DRAM side is precharging or refreshing.

The column can arrive in two ways. In static-column mode the latch strobe stays high and the bus follows the address pins. In page mode the address is captured when the strobe falls, and it is held for as long as the strobe stays low. The first access to a line takes a full access delay. When only the word-select bits change, a short burst delay applies instead, for at most three words in a row. The bus is released whenever the port is deselected, whenever the write path raises its read-inhibit, and whenever the addressed data is still in flight.

Top module: `rc_read_port`

## Requirements
- R1: During and straight after reset, `dq_oe` is 0. Whenever `dq_oe` is 0, `dq` reads all zeros.
- R2: When `dq_oe` is 1, `dq` holds bits [32*w+31 : 32*w] of the cache line whose index is column[10:2], where w = column[1:0].
- R3: A column on a new line, or the first column after selection, gives `dq_oe`=1 once ACC_CYC rising edges have sampled it (3 by default).
- R4: A column that differs from the one on display only in bits [1:0] gives `dq_oe`=1 after BURST_CYC edges (1 by default), provided the previous access had completed.
- R5: At most BURST_MAX (3) short accesses follow one full access. The next word-only change takes the full ACC_CYC delay.
- R6: With `col_lat_n` high, the column is `addr` itself. When it changes, `dq_oe` drops in the same cycle and a new access begins.
- R7: A falling edge of `col_lat_n` captures `addr`. While the strobe stays low, changes on `addr` have no effect on `dq` or on the column in use. Raising the strobe returns the port to static-column mode.
- R8: `dq_oe` is 0 in any cycle in which `cs_n` or `oe_n` is high. Selecting the port again starts a full-delay access.
- R9: `rd_inhibit` high forces `dq_oe` to 0 in the same cycle but leaves the access state intact. On release, completed data reappears at once.
- R10: A fill through `fill_en`/`fill_idx`/`fill_line` is visible on `dq` from the cycle after its clock edge, including for the line currently being read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| col_lat_n | input | 1 | Column latch strobe; high = static column, falling edge = page-mode capture |
| addr | input | 11 | Column address |
| rd_inhibit | input | 1 | Read-inhibit from the write path |
| fill_en | input | 1 | Load one cache line |
| fill_idx | input | 9 | Line index for the load |
| fill_line | input | 128 | Line data for the load |
| dq | output | 32 | Read data, zero when not driven |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
Two events can fall in the same cycle: a line fill and a read of that same line. The bench provokes this by refilling the line on display while its word is being driven. The check is that the new word shows up in the very next cycle and `dq_oe` never drops. A second overlap is a word-only address change arriving while a burst count is already exhausted. This is provoked by stepping through all four words of a line and then one more. The check is that the final step costs the full delay rather than the short one.

// File: rtl/rc_pkg.sv
package rc_pkg;
  parameter int COL_W  = 11;
  parameter int WORD_W = 32;
  parameter int SEL_W  = 2;
  localparam int WPL    = 1 << SEL_W;
  localparam int LINE_W = WORD_W * WPL;
  localparam int IDX_W  = COL_W - SEL_W;
  localparam int DEPTH  = 1 << IDX_W;

  typedef logic [COL_W-1:0]  col_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [SEL_W-1:0]  sel_t;
  typedef logic [LINE_W-1:0] line_t;
  typedef logic [WORD_W-1:0] word_t;

  function automatic idx_t line_of(col_t c);
    return c[COL_W-1:SEL_W];
  endfunction

  function automatic sel_t word_of(col_t c);
    return c[SEL_W-1:0];
  endfunction

  function automatic logic same_line(col_t a, col_t b);
    return line_of(a) == line_of(b);
  endfunction

  function automatic word_t pick(line_t l, sel_t s);
    return l[s*WORD_W +: WORD_W];
  endfunction
endpackage

// File: rtl/rc_col_capture.sv
module rc_col_capture
  import rc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lat_n,
  input  col_t addr,
  output col_t col_eff,
  output logic lat_fall,
  output logic lat_hold
);
  logic prev_q;
  col_t held_q;

  assign lat_fall = !lat_n && prev_q;
  assign lat_hold = !lat_n && !prev_q;
  assign col_eff  = lat_hold ? held_q : addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      held_q <= '0;
    end else begin
      prev_q <= lat_n;
      if (lat_fall) held_q <= addr;
    end
  end
endmodule

// File: rtl/rc_access_timer.sv
module rc_access_timer
  import rc_pkg::*;
#(
  parameter int ACC_CYC   = 3,
  parameter int BURST_CYC = 1,
  parameter int BURST_MAX = 3,
  localparam int CNT_W = $clog2(ACC_CYC + 1),
  localparam int BW    = $clog2(BURST_MAX + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  col_t             col_eff,
  output col_t             cur_col,
  output logic             ready,
  output logic             start_full,
  output logic             start_burst,
  output logic [CNT_W-1:0] wait_cnt,
  output logic [BW-1:0]    burst_cnt
);
  logic             armed_q;
  col_t             cur_q;
  logic [CNT_W-1:0] wait_q;
  logic [BW-1:0]    burst_q;
  logic             changed, burst_ok;

  assign changed  = !armed_q || (col_eff != cur_q);
  assign burst_ok = armed_q && (wait_q == '0) && same_line(col_eff, cur_q)
                    && (burst_q < BW'(BURST_MAX));
  assign start_full  = sel && changed && !burst_ok;
  assign start_burst = sel && changed && burst_ok;
  assign ready       = armed_q && (wait_q == '0) && !changed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cur_q   <= '0;
      wait_q  <= '0;
      burst_q <= '0;
    end else if (!sel) begin
      armed_q <= 1'b0;
      wait_q  <= '0;
      burst_q <= '0;
    end else if (start_full) begin
      armed_q <= 1'b1;
      cur_q   <= col_eff;
      wait_q  <= CNT_W'(ACC_CYC - 1);
      burst_q <= '0;
    end else if (start_burst) begin
      cur_q   <= col_eff;
      wait_q  <= CNT_W'(BURST_CYC - 1);
      burst_q <= burst_q + 1'b1;
    end else if (wait_q != '0) begin
      wait_q <= wait_q - 1'b1;
    end
  end

  assign cur_col   = cur_q;
  assign wait_cnt  = wait_q;
  assign burst_cnt = burst_q;
endmodule

// File: rtl/rc_line_store.sv
module rc_line_store
  import rc_pkg::*;
(
  input  logic  clk,
  input  logic  fill_en,
  input  idx_t  fill_idx,
  input  line_t fill_line,
  input  idx_t  rd_idx,
  output line_t rd_line
);
  line_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (fill_en) mem[fill_idx] <= fill_line;
  end

  assign rd_line = mem[rd_idx];
endmodule

// File: rtl/rc_read_port.sv
module rc_read_port
  import rc_pkg::*;
#(
  parameter int ACC_CYC   = 3,
  parameter int BURST_CYC = 1,
  parameter int BURST_MAX = 3
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  oe_n,
  input  logic                  col_lat_n,
  input  logic [COL_W-1:0]      addr,
  input  logic                  rd_inhibit,
  input  logic                  fill_en,
  input  logic [IDX_W-1:0]      fill_idx,
  input  logic [LINE_W-1:0]     fill_line,
  output logic [WORD_W-1:0]     dq,
  output logic                  dq_oe
);
  localparam int CNT_W = $clog2(ACC_CYC + 1);
  localparam int BW    = $clog2(BURST_MAX + 1);

  col_t             col_eff, cur_col;
  logic             lat_fall, lat_hold;
  logic             sel, ready, start_full, start_burst;
  logic [CNT_W-1:0] wait_cnt;
  logic [BW-1:0]    burst_cnt;
  line_t            rd_line;

  assign sel = !cs_n && !oe_n;

  rc_col_capture u_cap (
    .clk(clk), .rst_n(rst_n), .lat_n(col_lat_n), .addr(addr),
    .col_eff(col_eff), .lat_fall(lat_fall), .lat_hold(lat_hold)
  );

  rc_access_timer #(
    .ACC_CYC(ACC_CYC), .BURST_CYC(BURST_CYC), .BURST_MAX(BURST_MAX)
  ) u_tmr (
    .clk(clk), .rst_n(rst_n), .sel(sel), .col_eff(col_eff),
    .cur_col(cur_col), .ready(ready), .start_full(start_full),
    .start_burst(start_burst), .wait_cnt(wait_cnt), .burst_cnt(burst_cnt)
  );

  rc_line_store u_store (
    .clk(clk), .fill_en(fill_en), .fill_idx(fill_idx), .fill_line(fill_line),
    .rd_idx(line_of(cur_col)), .rd_line(rd_line)
  );

  assign dq_oe = sel && !rd_inhibit && ready;
  assign dq    = dq_oe ? pick(rd_line, word_of(cur_col)) : '0;
endmodule

// File: rtl/rc_read_port_chk.sv
module rc_read_port_chk
  import rc_pkg::*;
#(
  parameter int ACC_CYC   = 3,
  parameter int BURST_CYC = 1,
  parameter int BURST_MAX = 3,
  parameter int CNT_W     = 2,
  parameter int BW        = 2
)(
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             oe_n,
  input logic             rd_inhibit,
  input logic [WORD_W-1:0] dq,
  input logic             dq_oe,
  input logic             lat_hold,
  input col_t             col_eff,
  input logic             start_full,
  input logic             start_burst,
  input logic [CNT_W-1:0] wait_cnt,
  input logic [BW-1:0]    burst_cnt
);
  assert_idle_bus_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> dq == '0);
  assert_one_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_full, start_burst}));
  assert_full_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_full |=> int'(wait_cnt) == ACC_CYC - 1);
  assert_burst_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_burst |=> int'(wait_cnt) == BURST_CYC - 1);
  assert_burst_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_burst |-> int'(burst_cnt) < BURST_MAX);
  assert_page_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lat_hold |-> col_eff == $past(col_eff));
  assert_deselect_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || oe_n) |-> !dq_oe);
  assert_inhibit_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_inhibit |-> !dq_oe);
endmodule

bind rc_read_port rc_read_port_chk #(
  .ACC_CYC(ACC_CYC), .BURST_CYC(BURST_CYC), .BURST_MAX(BURST_MAX),
  .CNT_W(CNT_W), .BW(BW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .rd_inhibit(rd_inhibit),
  .dq(dq), .dq_oe(dq_oe), .lat_hold(lat_hold), .col_eff(col_eff),
  .start_full(start_full), .start_burst(start_burst),
  .wait_cnt(wait_cnt), .burst_cnt(burst_cnt)
);

// File: tb/test_rc_read_port.sv
module test_rc_read_port;
  import rc_pkg::*;
  localparam int ACC = 3;

  logic clk = 0, rst_n = 0, cs_n = 1, oe_n = 1, col_lat_n = 1, rd_inhibit = 0;
  logic fill_en = 0;
  col_t addr = '0;
  idx_t fill_idx = '0;
  line_t fill_line = '0;
  word_t dq;
  logic dq_oe;
  int checks = 0, errors = 0;
  line_t shadow [DEPTH];

  always #4 clk = ~clk;

  rc_read_port #(.ACC_CYC(ACC), .BURST_CYC(1), .BURST_MAX(3)) i_rc_read_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .col_lat_n(col_lat_n),
    .addr(addr), .rd_inhibit(rd_inhibit), .fill_en(fill_en), .fill_idx(fill_idx),
    .fill_line(fill_line), .dq(dq), .dq_oe(dq_oe)
  );

  function automatic line_t make_line(int idx, int seed);
    line_t l;
    for (int w = 0; w < WPL; w++)
      l[w*WORD_W +: WORD_W] = (32'(idx) * 32'h9E3779B1) ^ (32'(w) << 28) ^ 32'(seed);
    return l;
  endfunction

  function automatic word_t expect_word(col_t c);
    line_t l = shadow[c[COL_W-1:SEL_W]];
    return l[c[SEL_W-1:0]*WORD_W +: WORD_W];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fill(int idx, line_t l);
    fill_en = 1; fill_idx = idx_t'(idx); fill_line = l;
    cyc(1);
    fill_en = 0;
    shadow[idx] = l;
  endtask

  task automatic go(col_t a);
    addr = a; #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    col_t c;
    void'($urandom(32'd20240611));
    cyc(3);
    check("R1 oe in reset", 32'(dq_oe), 0);
    check("R1 dq in reset", dq, 0);
    rst_n = 1;
    for (int i = 0; i < DEPTH; i++) fill(i, make_line(i, 7));
    check("R1 oe after reset", 32'(dq_oe), 0);

    // R3: first access after select, full delay
    cs_n = 0; oe_n = 0; go(11'h104);
    cyc(2); check("R3 not yet", 32'(dq_oe), 0);
    cyc(1); check("R3 oe", 32'(dq_oe), 1);
    check("R2 word0", dq, expect_word(11'h104));
    // R4 bursts
    go(11'h105); check("R6 drop on change", 32'(dq_oe), 0);
    cyc(1); check("R4 burst1 oe", 32'(dq_oe), 1); check("R2 word1", dq, expect_word(11'h105));
    go(11'h106); cyc(1); check("R4 burst2", dq, expect_word(11'h106));
    go(11'h107); cyc(1); check("R4 burst3", dq, expect_word(11'h107));
    // R5: fourth word-only change is full delay
    go(11'h104); cyc(1); check("R5 no 4th burst", 32'(dq_oe), 0);
    cyc(1); check("R5 still waiting", 32'(dq_oe), 0);
    cyc(1); check("R5 full done", 32'(dq_oe), 1); check("R5 data", dq, expect_word(11'h104));
    // R6 static column, new line
    go(11'h3F2); cyc(2); check("R6 waiting", 32'(dq_oe), 0);
    cyc(1); check("R6 data", dq, expect_word(11'h3F2));
    // R7 page mode
    addr = 11'h51B; col_lat_n = 0; #1;
    cyc(1); go(11'h0A0);
    check("R7 access running", 32'(dq_oe), 0);
    cyc(2); check("R7 oe", 32'(dq_oe), 1);
    check("R7 captured column", dq, expect_word(11'h51B));
    go(11'h6C1); cyc(2); check("R7 addr ignored", dq, expect_word(11'h51B));
    col_lat_n = 1; #1; check("R7 release drop", 32'(dq_oe), 0);
    cyc(3); check("R7 static again", dq, expect_word(11'h6C1));
    // R9 inhibit
    rd_inhibit = 1; #1; check("R9 oe", 32'(dq_oe), 0); check("R1 dq zero", dq, 0);
    cyc(2); check("R9 held off", 32'(dq_oe), 0);
    rd_inhibit = 0; #1; check("R9 instant return", dq, expect_word(11'h6C1));
    // R8 deselect and reselect
    cs_n = 1; #1; check("R8 cs", 32'(dq_oe), 0);
    cyc(1); cs_n = 0; #1; check("R8 restart", 32'(dq_oe), 0);
    cyc(2); check("R8 full delay", 32'(dq_oe), 0);
    cyc(1); check("R8 back", dq, expect_word(11'h6C1));
    oe_n = 1; #1; check("R8 oe", 32'(dq_oe), 0);
    cyc(1); oe_n = 0; cyc(3); check("R8 oe back", 32'(dq_oe), 1);
    // R10 fill same line while reading
    fill(11'h6C1 >> 2, make_line(99, 32'h5A5A));
    check("R10 oe kept", 32'(dq_oe), 1);
    check("R10 new data", dq, expect_word(11'h6C1));

    // random phase
    for (int it = 0; it < 300; it++) begin
      int k;
      if ($urandom % 3 == 0) c = {addr[COL_W-1:SEL_W], SEL_W'($urandom)};
      else c = COL_W'($urandom);
      go(c);
      k = 0;
      while (!dq_oe && k < ACC + 1) begin cyc(1); k++; end
      check("R3 latency bound", 32'(k <= ACC), 1);
      check("R2 random word", dq, expect_word(c));
      if ($urandom % 4 == 0) begin
        fill(int'(c[COL_W-1:SEL_W]), make_line(it, int'($urandom)));
        check("R10 random fill", dq, expect_word(c));
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule